// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer with Timestamp Counter

This block combines two time bases behind a small register port. A free-running timestamp counter advances by one on every clock and can be read at any time. Software can restart it by writing zero, or preload it with any other value. Next to it sits a general-purpose down-counter whose reload register carries two control options in its lowest bits. That down-counter fires an interrupt either periodically or once.

The reload register's two lowest bit positions are never part of the count. Bit 0 is the enable and bit 1 selects one-shot operation. The value loaded into the down-counter is always the written word with both of those bits cleared. The counter is loaded as soon as the reload register is written. When the counter is found at zero while the timer is running, the timer expires. A periodic timer then reloads and keeps going. A one-shot timer clears its enable bit and stops.

The timer control is a two-state machine. In `ST_IDLE` the counter holds. In `ST_RUN` it counts down. The transitions are:
- load-enable (`ST_IDLE`/`ST_RUN` → `ST_RUN`): the reload register is written with bit 0 set.
- load-disable (any → `ST_IDLE`): the reload register is written with bit 0 clear.
- periodic-expire (`ST_RUN` → `ST_RUN`): the counter is at zero with one-shot clear, so it reloads.
- oneshot-expire (`ST_RUN` → `ST_IDLE`): the counter is at zero with one-shot set.

Each expiry sets a sticky pending flag, which drives the interrupt output until software writes 1 to clear it.

Top module: `os_timer`

## Requirements
- R1: After reset, all four registers read zero, the timer is idle and `irq` is low.
- R2: The timestamp (address 0) increases by one on every clock edge without a write to it, wrapping from all ones to zero.
- R3: A write to address 0 loads the timestamp with the written value on that edge, taking precedence over the increment; writing zero restarts it from zero.
- R4: A write to the reload register (address 1) stores the full word, which reads back unchanged. Bit 0 is enable and bit 1 is one-shot. The down-counter (readable at address 2) is loaded on the same edge with the word's two lowest bits cleared.
- R5: While enabled and nonzero, the down-counter decreases by one per clock; while disabled it holds its value.
- R6: An enabled timer whose counter is zero at a clock edge expires on that edge and sets the pending flag. In periodic mode the counter reloads with the masked value, so expiries repeat every masked value + 1 cycles.
- R7: On a one-shot expiry, bit 0 of the reload register clears, the counter stays at zero and no further expiry occurs.
- R8: Writing zero to the reload register stops the timer and clears the counter; no expiry follows. A reload write in the cycle where the counter is zero replaces the expiry.
- R9: Writing the status register (address 3) with bit 0 set clears the pending flag, and with bit 0 clear has no effect. An expiry on the same edge as a clear leaves the flag set.
- R10: `irq` equals the pending flag, which also reads as bit 0 of address 3; the other status bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 timestamp, 1 reload, 2 count, 3 status |
| wdata | input | W | Write data |
| rdata | output | W | Read data for the selected register (combinational) |
| irq | output | 1 | Expiry interrupt, high while the pending flag is set |

## Verification
Two pairs of events can land on the same edge. In the first, an expiry coincides with a software clear of the pending flag. The bench programs a periodic reload of 4 and issues the clear exactly five edges later, then expects the flag to remain set. In the second, a reload write arrives while the counter is at zero. That is provoked directly, and also many times over by the random stream. It is judged against a per-cycle bench model in which the write replaces the expiry.

// File: rtl/os_timer_pkg.sv
package os_timer_pkg;
    localparam int OPT_W    = 2;
    localparam int EN_BIT   = 0;
    localparam int ONE_BIT  = 1;

    typedef enum logic [1:0] {
        A_STAMP  = 2'd0,
        A_RELOAD = 2'd1,
        A_COUNT  = 2'd2,
        A_STATUS = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/os_timer_stamp.sv
module os_timer_stamp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wval,
    output logic [W-1:0] ts_q
);
    // A software write wins over the increment on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ts_q <= '0;
        else if (wr)
            ts_q <= wval;
        else
            ts_q <= ts_q + W'(1);
    end
endmodule

// File: rtl/os_timer_down.sv
module os_timer_down
    import os_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] rl_q,
    output logic [W-1:0] cnt_q,
    output logic         expire,
    output logic         running
);
    localparam logic [W-1:0] CNT_MASK = {{(W-OPT_W){1'b1}}, {OPT_W{1'b0}}};

    tmr_state_e   state_q, state_d;
    logic [W-1:0] rl_d, cnt_d;
    logic         hit;

    // Next-state and datapath decisions.
    always_comb begin
        state_d = state_q;
        rl_d    = rl_q;
        cnt_d   = cnt_q;
        hit     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = cnt_q;
            end
            ST_RUN: begin
                if (cnt_q == '0) begin
                    hit = 1'b1;
                    if (rl_q[ONE_BIT]) begin
                        rl_d[EN_BIT] = 1'b0;     // oneshot-expire
                        state_d      = ST_IDLE;
                    end else begin
                        cnt_d = rl_q & CNT_MASK; // periodic-expire
                    end
                end else begin
                    cnt_d = cnt_q - W'(1);
                end
            end
        endcase
        // Software load replaces any expiry in the same cycle.
        if (ld) begin
            hit     = 1'b0;
            rl_d    = ld_val;
            cnt_d   = ld_val & CNT_MASK;
            state_d = ld_val[EN_BIT] ? ST_RUN : ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rl_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            rl_q    <= rl_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        expire  = hit;
        running = (state_q == ST_RUN);
    end
endmodule

// File: rtl/os_timer_pend.sv
module os_timer_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pend_q
);
    // Set dominates a same-edge clear so an expiry is never lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (set)
            pend_q <= 1'b1;
        else if (clr)
            pend_q <= 1'b0;
    end
endmodule

// File: rtl/os_timer.sv
module os_timer
    import os_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         irq
);
    logic [W-1:0] ts_q, rl_q, cnt_q;
    logic         expire, running, pend_q;
    logic         wr_ts, wr_rl, wr_st;

    always_comb begin
        wr_ts = wr_en && (addr == A_STAMP);
        wr_rl = wr_en && (addr == A_RELOAD);
        wr_st = wr_en && (addr == A_STATUS);
    end

    os_timer_stamp #(.W(W)) u_stamp (
        .clk(clk), .rst_n(rst_n), .wr(wr_ts), .wval(wdata), .ts_q(ts_q)
    );

    os_timer_down #(.W(W)) u_down (
        .clk(clk), .rst_n(rst_n), .ld(wr_rl), .ld_val(wdata),
        .rl_q(rl_q), .cnt_q(cnt_q), .expire(expire), .running(running)
    );

    os_timer_pend u_pend (
        .clk(clk), .rst_n(rst_n), .set(expire),
        .clr(wr_st && wdata[0]), .pend_q(pend_q)
    );

    always_comb begin
        unique case (addr)
            A_STAMP:  rdata = ts_q;
            A_RELOAD: rdata = rl_q;
            A_COUNT:  rdata = cnt_q;
            default:  rdata = {{(W-1){1'b0}}, pend_q};
        endcase
    end

    assign irq = pend_q;
endmodule

// File: rtl/os_timer_chk.sv
module os_timer_chk
    import os_timer_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] wdata,
    input logic         irq,
    input logic [W-1:0] ts,
    input logic [W-1:0] cnt,
    input logic [W-1:0] rl,
    input logic         running,
    input logic         expire
);
    assert_ts_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_STAMP) |=> ts == $past(ts) + W'(1));

    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cnt != '0 && !(wr_en && addr == A_RELOAD)) |=> cnt == $past(cnt) - W'(1));

    assert_expire_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && rl[ONE_BIT]) |=> (!running && !rl[EN_BIT] && cnt == '0));

    assert_zero_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RELOAD && wdata == '0) |=> (!running && cnt == '0 && !expire));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STATUS && wdata[0] && !expire) |=> !irq);

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(wr_en && addr == A_RELOAD)) |=> $stable(cnt));
endmodule

bind os_timer os_timer_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .ts(ts_q), .cnt(cnt_q), .rl(rl_q), .running(running),
    .expire(expire)
);

// File: tb/os_timer_tb.sv
`timescale 1ns/1ps
module os_timer_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [W-1:0] m_ts, m_rl, m_cnt;
    logic         m_run, m_pend;

    os_timer #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [W-1:0] masked(input logic [W-1:0] v);
        return v & ~W'(3);
    endfunction

    function automatic logic [W-1:0] model_read(input int a);
        case (a)
            0: return m_ts;
            1: return m_rl;
            2: return m_cnt;
            default: return {{(W-1){1'b0}}, m_pend};
        endcase
    endfunction

    // Advance the model by one edge, given the inputs applied at it.
    task automatic model_step(input bit we, input int a, input logic [W-1:0] d);
        bit exp_now = 1'b0;
        m_ts = (we && a == 0) ? d : m_ts + W'(1);
        if (we && a == 1) begin
            m_rl = d; m_cnt = masked(d); m_run = d[0];
        end else if (m_run) begin
            if (m_cnt == '0) begin
                exp_now = 1'b1;
                if (m_rl[1]) begin m_rl[0] = 1'b0; m_run = 1'b0; end
                else m_cnt = masked(m_rl);
            end else m_cnt = m_cnt - W'(1);
        end
        if (exp_now) m_pend = 1'b1;
        else if (we && a == 3 && d[0]) m_pend = 1'b0;
    endtask

    task automatic cyc(input bit we, input int a, input logic [W-1:0] d);
        wr_en = we; addr = 2'(a); wdata = d;
        @(posedge clk);
        model_step(we, a, d);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input int a);
        addr = 2'(a); #0.1;
        checks++;
        if (rdata !== model_read(a)) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", req, a, rdata, model_read(a));
        end
    endtask

    task automatic chk_all(input string req);
        for (int a = 0; a < 4; a++) chk(req, a);
        checks++;
        if (irq !== m_pend) begin
            errors++;
            $display("FAIL %s irq actual %b expected %b", req, irq, m_pend);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        m_ts = '0; m_rl = '0; m_cnt = '0; m_run = 1'b0; m_pend = 1'b0;
        #1;
        chk_all("R1 reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        // first edge after release: timestamp increments
        cyc(0, 0, '0);
        chk_all("R1 R2 after reset");

        // R2 wrap: preload all ones, next edge wraps
        cyc(1, 0, '1);
        chk_all("R3 load");
        cyc(0, 0, '0);
        chk_all("R2 wrap");
        // R3 restart by zero
        cyc(1, 0, '0);
        chk_all("R3 zero");

        // R4/R5/R6 periodic reload 4 (+opts 01 -> 5), period 5; clear collides with expiry (R9)
        cyc(1, 1, 32'd5);
        chk_all("R4 load masked");
        for (int i = 0; i < 4; i++) begin cyc(0, 2, '0); chk_all("R5 count"); end
        cyc(1, 3, 32'd1);   // expiry on this edge, clear loses
        chk_all("R9 set wins");
        checks++;
        if (irq !== 1'b1) begin errors++; $display("FAIL R9 irq actual %b expected 1", irq); end
        cyc(1, 3, 32'd2);   // bit0 clear: no effect
        chk_all("R9 no effect");
        cyc(1, 3, 32'd1);
        chk_all("R9 clear");
        for (int i = 0; i < 6; i++) begin cyc(0, 2, '0); chk_all("R6 periodic"); end

        // R7 one-shot with reload 8
        cyc(1, 1, 32'd11);
        for (int i = 0; i < 14; i++) begin cyc(0, 2, '0); chk_all("R7 oneshot"); end

        // R8 reload written in the cycle the counter is zero
        cyc(1, 1, 32'd1);
        cyc(1, 1, 32'd9);
        chk_all("R8 write over expiry");
        cyc(1, 1, '0);
        chk_all("R8 stop");
        for (int i = 0; i < 4; i++) begin cyc(0, 1, '0); chk_all("R8 stays stopped"); end

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int op = int'($urandom_range(0, 9));
            case (op)
                0, 1: cyc(1, 1, W'($urandom_range(0, 40)));
                2:    cyc(1, 3, W'($urandom_range(0, 3)));
                3:    cyc(1, 0, ($urandom_range(0, 3) == 0) ? '0 : W'($urandom()));
                default: cyc(0, int'($urandom_range(0, 3)), W'($urandom()));
            endcase
            chk_all("R2 R4 R5 R6 R7 R10 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule